// File: doc/BRIEF.md
# Latched BCD Segment Driver

This block holds one binary-coded decimal digit and turns it into the seven on/off levels of a segment display. A load input controls the storage element. While load is high, the digit input passes into the stored code. While load is low, the stored code stays put and changes on the digit input have no effect. A blank input darkens the display without disturbing the stored code. Codes above nine are also shown dark.

A phase input inverts all seven outputs together. Tie it low for LEDs that share a cathode. Tie it high for LEDs that share an anode. For a liquid-crystal panel, drive it with a square wave that also drives the panel's common backplane.

The block can also make that square wave itself. With the LCD enable set, a clock divider toggles the backplane output. The divider's output then takes the place of the external phase input, so every segment is driven in or out of phase with the backplane. The parameter `LEVEL_LATCH` selects the storage element:
- 0 (default): a clocked register that loads on every rising clock edge while load is high.
- 1: a transparent level-sensitive latch.

Top module: `bcd_seg_driver`

## Requirements
- R1: With `load` high, the code on `digit` is stored at the next rising clock edge, and `seg` shows it from that edge on.
- R2: With `load` low, the stored code and `seg` do not change, whatever `digit` does.
- R3: `seg[6]` through `seg[0]` are segments a through g. A 1 means lit when the effective phase is 0. The digits 0 to 9 give these patterns (a..g): 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1111011.
- R4: Stored codes 10 through 15 give all segments unlit, the same as blanking.
- R5: With `blank` high, all segments are unlit whatever the stored or incoming code. The stored code is kept, and the result still passes through phase inversion.
- R6: With `phase` high and `lcd_en` low, every bit of `seg` is the inverse of the phase-0 pattern. This includes blank and invalid codes, which then read 1111111.
- R7: With `lcd_en` high, the effective phase is `backplane` and `phase` is ignored. `backplane` toggles once every `div_count`+1 clock edges. Each `seg` bit equals `backplane` XOR the bit's lit state. With `lcd_en` low, `backplane` is 0.
- R8: `rst_n` low asynchronously clears the stored code to 0 and `backplane` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the storage register and the backplane divider |
| rst_n | input | 1 | Asynchronous reset, active low |
| digit | input | 4 | BCD code, weighted 8-4-2-1, bit 0 least significant |
| load | input | 1 | High: capture `digit`; low: hold |
| blank | input | 1 | High: force all segments unlit |
| phase | input | 1 | External polarity; high inverts all outputs |
| lcd_en | input | 1 | High: internal backplane drives the polarity |
| div_count | input | DIV_W | Backplane half period, minus one, in clock cycles |
| seg | output | 7 | Segment levels, bit 6 = a ... bit 0 = g |
| backplane | output | 1 | Square wave for the panel's common electrode |

## Verification
The blank input and the capture of a new code can fall in the same cycle. The bench raises `blank` and `load` together with a fresh digit. It then checks that the outputs are dark at the inverted or plain level, depending on phase. After `blank` drops with `load` low, it checks that the newly captured digit appears, which shows that blanking did not stop the capture. Polarity and invalid-code suppression also coincide. Code 12 is stored under both phase levels and judged against all-0 and all-1 outputs.

// File: rtl/bcd_seg_driver.sv
module bcd_seg_driver #(
  parameter bit LEVEL_LATCH = 1'b0,
  parameter int DIV_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       digit,
  input  logic             load,
  input  logic             blank,
  input  logic             phase,
  input  logic             lcd_en,
  input  logic [DIV_W-1:0] div_count,
  output logic [6:0]       seg,
  output logic             backplane
);

  logic [3:0]       code_q;
  logic [DIV_W-1:0] cnt_q;
  logic             bp_q;
  logic             pol;
  logic [6:0]       lit;

  generate
    if (LEVEL_LATCH) begin : g_latch
      always_latch begin
        if (!rst_n)    code_q <= 4'd0;
        else if (load) code_q <= digit;
      end
    end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    code_q <= 4'd0;
        else if (load) code_q <= digit;
      end

      p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(code_q));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bp_q  <= 1'b0;
    end else if (!lcd_en) begin
      cnt_q <= '0;
      bp_q  <= 1'b0;
    end else if (cnt_q >= div_count) begin
      cnt_q <= '0;
      bp_q  <= ~bp_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    case (code_q)
      4'd0:    lit = 7'b1111110;
      4'd1:    lit = 7'b0110000;
      4'd2:    lit = 7'b1101101;
      4'd3:    lit = 7'b1111001;
      4'd4:    lit = 7'b0110011;
      4'd5:    lit = 7'b1011011;
      4'd6:    lit = 7'b1011111;
      4'd7:    lit = 7'b1110000;
      4'd8:    lit = 7'b1111111;
      4'd9:    lit = 7'b1111011;
      default: lit = 7'b0000000;
    endcase
  end

  assign pol       = lcd_en ? bp_q : phase;
  assign seg       = (blank ? 7'b0000000 : lit) ^ {7{pol}};
  assign backplane = bp_q;

  p_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && !lcd_en) |-> (seg == {7{phase}}));

  p_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((code_q > 4'd9) && !lcd_en) |-> (seg == {7{phase}}));

  p_bp_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en && (cnt_q < div_count)) |=> $stable(backplane));

  p_eight_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en && !blank && (code_q == 4'd8)) |-> (seg == {7{~backplane}}));

  p_bp_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_en |=> !backplane);

endmodule

// File: tb/tb_bcd_seg_driver.sv
module tb_bcd_seg_driver;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [3:0]       digit = 4'd0;
  logic             load = 1'b0;
  logic             blank = 1'b0;
  logic             phase = 1'b0;
  logic             lcd_en = 1'b0;
  logic [DIV_W-1:0] div_count = '0;
  logic [6:0]       seg;
  logic             backplane;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bcd_seg_driver #(.LEVEL_LATCH(1'b0), .DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .digit(digit), .load(load), .blank(blank),
    .phase(phase), .lcd_en(lcd_en), .div_count(div_count),
    .seg(seg), .backplane(backplane)
  );

  always #10 clk = ~clk;

  function automatic logic [6:0] glyph(input logic [3:0] c);
    case (c)
      4'd0: return 7'b1111110;
      4'd1: return 7'b0110000;
      4'd2: return 7'b1101101;
      4'd3: return 7'b1111001;
      4'd4: return 7'b0110011;
      4'd5: return 7'b1011011;
      4'd6: return 7'b1011111;
      4'd7: return 7'b1110000;
      4'd8: return 7'b1111111;
      4'd9: return 7'b1111011;
      default: return 7'b0000000;
    endcase
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic store(input logic [3:0] c);
    @(negedge clk);
    digit = c; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    #1;
    check("R8 seg in reset", seg, glyph(4'd0));
    check("R8 backplane in reset", {6'd0, backplane}, 7'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 code 0 after reset", seg, 7'b1111110);
  endtask

  task automatic t_decode_all;
    for (int ph = 0; ph < 2; ph++) begin
      phase = ph[0];
      for (int c = 0; c < 16; c++) begin
        store(c[3:0]);
        if (c < 10) check("R3 R1 R6 digit pattern", seg, glyph(c[3:0]) ^ {7{ph[0]}});
        else        check("R4 R6 invalid code dark", seg, {7{ph[0]}});
      end
    end
    phase = 1'b0;
  endtask

  task automatic t_hold;
    store(4'd5);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      digit = c[3:0];
      @(negedge clk);
      check("R2 hold while load low", seg, glyph(4'd5));
    end
  endtask

  task automatic t_blank;
    store(4'd3);
    @(negedge clk);
    blank = 1'b1; phase = 1'b0;
    #1 check("R5 blank dark", seg, 7'b0000000);
    phase = 1'b1;
    #1 check("R5 R6 blank inverted", seg, 7'b1111111);
    digit = 4'd7; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check("R5 blank wins over fresh load", seg, 7'b1111111);
    phase = 1'b0;
    #1 check("R5 blank wins at phase 0", seg, 7'b0000000);
    blank = 1'b0;
    #1 check("R5 R1 code captured under blank", seg, glyph(4'd7));
  endtask

  task automatic t_lcd;
    logic prev;
    int run;
    int toggles;
    store(4'd2);
    @(negedge clk);
    div_count = 8'd3; phase = 1'b1; lcd_en = 1'b1;
    prev = 1'b0; run = 0; toggles = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check("R7 segment equals backplane xor lit", seg, glyph(4'd2) ^ {7{backplane}});
      if (backplane !== prev) begin
        if (toggles == 0) check("R7 first toggle after 4 edges", run[6:0], 7'd3);
        else              check("R7 toggle spacing 4 edges", run[6:0], 7'd4);
        toggles++; run = 1; prev = backplane;
      end else run++;
    end
    check("R7 backplane toggled", (toggles >= 8) ? 7'd1 : 7'd0, 7'd1);
    blank = 1'b1;
    #1 check("R7 R5 blank follows backplane", seg, {7{backplane}});
    blank = 1'b0;
    lcd_en = 1'b0; phase = 1'b0;
    @(negedge clk);
    check("R7 backplane low when disabled", {6'd0, backplane}, 7'd0);
    check("R7 external phase back in use", seg, glyph(4'd2));
  endtask

  initial begin
    t_reset();
    t_decode_all();
    t_hold();
    t_blank();
    t_lcd();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule